// File: doc/BRIEF.md
# Video Memory Page Mapper

This block turns addresses from two different requesters into physical addresses in a memory that video and host share. Both translations are steered by one 8-bit page register that the host writes. The display side gives a character or pixel address and the current row-scan line. The block then returns the byte address that the display fetch logic must read. That address always lies in the lowest 128 KB, in one of eight 16 KB pages.

The host side gives a 20-bit memory address. An address that falls inside the fixed 32 KB video window at B8000h is redirected into a second, independently chosen 16 KB page. Any other address leaves the block unchanged. A configuration input reports whether expansion memory is fitted. When it is not, only the four lowest pages can be reached.

The upper two register bits pick an address mode. The mode decides how many row-scan bits are woven into the fetch address. This lets graphics modes interleave scan lines across 8 KB banks, while text modes read character and attribute pairs in sequence.

Top module: `vid_page_map`

## Requirements
- R1: After reset the page register holds 0. The fetch address is then twice the display address, and window hits land in page 0.
- R2: A write loads reg_wr_data into the register at the clock edge where reg_wr_en is high, and outputs reflect it from the following cycle. When reg_wr_en is low the register keeps its value whatever reg_wr_data carries.
- R3: Register bits 2:0 select the display page, so fetch_addr = display page × 16384 + offset. fetch_addr bits 19:17 and bit 0 are always 0.
- R4: A host address from B8000h to BFFFFh sets host_hit to 1. host_phys is then register bits 5:3 × 16384 + host_addr[13:0], so host_addr bit 14 is dropped and both 16 KB halves of the window alias.
- R5: A host address outside B8000h–BFFFFh sets host_hit to 0 and host_phys to host_addr unchanged.
- R6: When ext_ram_present is 0, bit 2 of the display page and bit 2 of the host page are treated as 0.
- R7: Address mode 00 (register bits 7:6) is text. fetch_addr[13:1] = disp_addr[12:0], and row_scan has no effect.
- R8: Address mode 01 is low-resolution graphics. fetch_addr[13] = row_scan[0], fetch_addr[12:1] = disp_addr[11:0], and row_scan[1] and disp_addr[12] have no effect.
- R9: Address mode 11 is high-resolution graphics. fetch_addr[14:13] = row_scan[1:0] and fetch_addr[12:1] = disp_addr[11:0]. Bit 0 of the display page is treated as 0, which gives 32 KB alignment.
- R10: The reserved address mode 10 behaves exactly like mode 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_ram_present | input | 1 | 1 when expansion memory is fitted (eight pages usable) |
| reg_wr_en | input | 1 | Host write strobe for the page register |
| reg_wr_data | input | 8 | Value written: [2:0] display page, [5:3] host page, [7:6] address mode |
| disp_addr | input | 13 | Character or pixel address from the display timing logic |
| row_scan | input | 2 | Low bits of the current row-scan line |
| fetch_addr | output | 20 | Physical byte address for the display fetch |
| host_addr | input | 20 | Host memory-cycle address |
| host_phys | output | 20 | Physical address for the host cycle after redirection |
| host_hit | output | 1 | 1 when host_addr falls inside the video window |

## Verification
The register is the only state in the block. A wrong bit in it shows up at the ports in the very first cycle after the write that set it. Each page-select error moves fetch_addr or host_phys by a multiple of 16384, and each mode error changes which bits row_scan drives. The bench therefore keeps its own copy of the register and compares all three outputs in every cycle. It varies row_scan and disp_addr freely, so that a wrongly decoded mode or a missing don't-care mask cannot hide behind a lucky input value.

// File: rtl/vpm_pkg.sv
package vpm_pkg;

  localparam int REG_W     = 8;
  localparam int PG_W      = 3;
  localparam int PAGE_LOG2 = 14;
  localparam int ROW_W     = 2;
  localparam int DISP_W    = PAGE_LOG2 - 1;
  localparam int MAP_W     = PG_W + PAGE_LOG2;
  localparam int WIN_LOG2  = PAGE_LOG2 + 1;

  typedef enum logic [1:0] {
    AM_TEXT  = 2'b00,
    AM_LORES = 2'b01,
    AM_RSVD  = 2'b10,
    AM_HIRES = 2'b11
  } amode_e;

  typedef struct packed {
    amode_e          mode;
    logic [PG_W-1:0] cpu_pg;
    logic [PG_W-1:0] crt_pg;
  } page_reg_t;

endpackage

// File: rtl/vpm_rst_sync.sv
module vpm_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/vpm_page_reg.sv
module vpm_page_reg
  import vpm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             ext_ram,
  output logic [PG_W-1:0]  crt_pg,
  output logic [PG_W-1:0]  cpu_pg,
  output amode_e           mode
);

  page_reg_t pg_q;
  page_reg_t pg_d;

  always_comb begin
    pg_d = page_reg_t'(wr_data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_q <= '0;
    end else if (wr_en) begin
      pg_q <= pg_d;
    end
  end

  // effective selects after don't-care masking
  always_comb begin
    crt_pg = pg_q.crt_pg;
    cpu_pg = pg_q.cpu_pg;
    mode   = pg_q.mode;
    if (!ext_ram) begin
      crt_pg[PG_W-1] = 1'b0;
      cpu_pg[PG_W-1] = 1'b0;
    end
    if (pg_q.mode == AM_HIRES) begin
      crt_pg[0] = 1'b0;
    end
  end

  assert_wr_load_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (pg_q == page_reg_t'($past(wr_data))));

  assert_wr_hold_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(pg_q));

endmodule

// File: rtl/vpm_fetch_map.sv
module vpm_fetch_map
  import vpm_pkg::*;
#(
  parameter int PHYS_W = 20
) (
  input  logic [PG_W-1:0]   crt_pg,
  input  amode_e            mode,
  input  logic [DISP_W-1:0] disp_addr,
  input  logic [ROW_W-1:0]  row_scan,
  output logic [PHYS_W-1:0] fetch_addr
);

  localparam int OFS_W = PAGE_LOG2 + 1;

  logic [OFS_W-1:0] ofs;
  logic [MAP_W-1:0] base;
  logic [MAP_W-1:0] sum;

  always_comb begin
    unique case (mode)
      AM_LORES: ofs = {1'b0, row_scan[0], disp_addr[DISP_W-2:0], 1'b0};
      AM_HIRES: ofs = {row_scan[1], row_scan[0], disp_addr[DISP_W-2:0], 1'b0};
      default:  ofs = {1'b0, disp_addr, 1'b0};
    endcase
  end

  always_comb begin
    base = {crt_pg, {PAGE_LOG2{1'b0}}};
    sum  = base + MAP_W'(ofs);
  end

  if (PHYS_W > MAP_W) begin : g_pad
    assign fetch_addr = {{(PHYS_W-MAP_W){1'b0}}, sum};
  end else begin : g_exact
    assign fetch_addr = sum;
  end

endmodule

// File: rtl/vpm_host_map.sv
module vpm_host_map
  import vpm_pkg::*;
#(
  parameter int                PHYS_W   = 20,
  parameter logic [PHYS_W-1:0] WIN_BASE = 20'hB8000
) (
  input  logic [PG_W-1:0]   cpu_pg,
  input  logic [PHYS_W-1:0] host_addr,
  output logic [PHYS_W-1:0] host_phys,
  output logic              host_hit
);

  localparam logic [PHYS_W-WIN_LOG2-1:0] WIN_TAG = WIN_BASE[PHYS_W-1:WIN_LOG2];

  logic [PHYS_W-1:0] redirect;

  always_comb begin
    host_hit = (host_addr[PHYS_W-1:WIN_LOG2] == WIN_TAG);
  end

  if (PHYS_W > MAP_W) begin : g_pad
    assign redirect = {{(PHYS_W-MAP_W){1'b0}}, cpu_pg, host_addr[PAGE_LOG2-1:0]};
  end else begin : g_exact
    assign redirect = {cpu_pg, host_addr[PAGE_LOG2-1:0]};
  end

  always_comb begin
    host_phys = host_hit ? redirect : host_addr;
  end

endmodule

// File: rtl/vid_page_map.sv
module vid_page_map
  import vpm_pkg::*;
#(
  parameter int                PHYS_W   = 20,
  parameter logic [PHYS_W-1:0] WIN_BASE = 20'hB8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_ram_present,
  input  logic              reg_wr_en,
  input  logic [REG_W-1:0]  reg_wr_data,
  input  logic [DISP_W-1:0] disp_addr,
  input  logic [ROW_W-1:0]  row_scan,
  output logic [PHYS_W-1:0] fetch_addr,
  input  logic [PHYS_W-1:0] host_addr,
  output logic [PHYS_W-1:0] host_phys,
  output logic              host_hit
);

  localparam logic [PHYS_W:0] WIN_END = {1'b0, WIN_BASE} + ((PHYS_W+1)'(1) << WIN_LOG2);

  logic            rst_n_core;
  logic [PG_W-1:0] crt_pg;
  logic [PG_W-1:0] cpu_pg;
  amode_e          mode;

  vpm_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_core)
  );

  vpm_page_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n_core),
    .wr_en   (reg_wr_en),
    .wr_data (reg_wr_data),
    .ext_ram (ext_ram_present),
    .crt_pg  (crt_pg),
    .cpu_pg  (cpu_pg),
    .mode    (mode)
  );

  vpm_fetch_map #(.PHYS_W(PHYS_W)) u_fetch (
    .crt_pg     (crt_pg),
    .mode       (mode),
    .disp_addr  (disp_addr),
    .row_scan   (row_scan),
    .fetch_addr (fetch_addr)
  );

  vpm_host_map #(.PHYS_W(PHYS_W), .WIN_BASE(WIN_BASE)) u_host (
    .cpu_pg    (cpu_pg),
    .host_addr (host_addr),
    .host_phys (host_phys),
    .host_hit  (host_hit)
  );

  assert_passthru_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    ((host_addr < WIN_BASE) || ({1'b0, host_addr} >= WIN_END))
      |-> (!host_hit && (host_phys == host_addr)));

  assert_noexp_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    !ext_ram_present |-> (!fetch_addr[MAP_W-1] && (!host_hit || !host_phys[MAP_W-1])));

  assert_lores_row_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    (mode == AM_LORES) |-> (fetch_addr[PAGE_LOG2-1] == row_scan[0]));

  assert_hires_row_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    (mode == AM_HIRES) |-> (fetch_addr[PAGE_LOG2:PAGE_LOG2-1] == row_scan));

  assert_fetch_low_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    $changed(fetch_addr) |-> (fetch_addr < (PHYS_W'(1) << MAP_W)));

endmodule

// File: tb/vid_page_map_test.sv
module vid_page_map_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ext_ram_present;
  logic        reg_wr_en;
  logic [7:0]  reg_wr_data;
  logic [12:0] disp_addr;
  logic [1:0]  row_scan;
  logic [19:0] fetch_addr;
  logic [19:0] host_addr;
  logic [19:0] host_phys;
  logic        host_hit;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    chk_en = 1'b0;
  int    seed = 7;
  logic [7:0] mreg;

  always #5 clk = ~clk;

  vid_page_map uut (
    .clk             (clk),
    .rst_n           (rst_n),
    .ext_ram_present (ext_ram_present),
    .reg_wr_en       (reg_wr_en),
    .reg_wr_data     (reg_wr_data),
    .disp_addr       (disp_addr),
    .row_scan        (row_scan),
    .fetch_addr      (fetch_addr),
    .host_addr       (host_addr),
    .host_phys       (host_phys),
    .host_hit        (host_hit)
  );

  // reference register
  always @(posedge clk) begin
    if (!rst_n) mreg <= 8'h00;
    else if (reg_wr_en) mreg <= reg_wr_data;
  end

  function automatic int exp_fetch(int r, int ext, int disp, int row);
    int pg, md, off;
    pg = r % 8;
    md = (r / 64) % 4;
    if (ext == 0) pg = pg % 4;
    if (md == 3) pg = pg - (pg % 2);
    if (md == 1)      off = (row % 2) * 8192 + (disp % 4096) * 2;
    else if (md == 3) off = (row % 4) * 8192 + (disp % 4096) * 2;
    else              off = (disp % 8192) * 2;
    return pg * 16384 + off;
  endfunction

  function automatic int exp_host(int r, int ext, int a, output int hit);
    int pg;
    pg = (r / 8) % 8;
    if (ext == 0) pg = pg % 4;
    if (a >= 'hB8000 && a <= 'hBFFFF) begin
      hit = 1;
      return pg * 16384 + (a % 16384);
    end
    hit = 0;
    return a;
  endfunction

  task automatic report(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h (reg=%h disp=%h row=%0d host=%h)",
               req, what, act, exp, mreg, disp_addr, row_scan, host_addr);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en) begin
      int eh, ef, hp;
      ef = exp_fetch(int'(mreg), int'(ext_ram_present), int'(disp_addr), int'(row_scan));
      hp = exp_host(int'(mreg), int'(ext_ram_present), int'(host_addr), eh);
      report(cur_req, "fetch_addr", int'(fetch_addr), ef);
      report(cur_req, "host_phys", int'(host_phys), hp);
      report(cur_req, "host_hit", int'(host_hit), eh);
    end
  end

  function automatic int rnd(int modv);
    seed = seed * 1103515245 + 12345;
    return ((seed >>> 8) & 32'h7fffffff) % modv;
  endfunction

  task automatic apply(bit we, int data, int disp, int row, int ha);
    @(posedge clk);
    #1;
    reg_wr_en   = we;
    reg_wr_data = data[7:0];
    disp_addr   = disp[12:0];
    row_scan    = row[1:0];
    host_addr   = ha[19:0];
  endtask

  task automatic idle_mix(int n);
    for (int k = 0; k < n; k++) begin
      apply(1'b0, rnd(256), rnd(8192), rnd(4), (k % 2 == 0) ? ('hB8000 + rnd(32768)) : rnd(1048576));
    end
  endtask

  task automatic write_reg(int v);
    apply(1'b1, v, rnd(8192), rnd(4), 'hB8000 + rnd(32768));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ext_ram_present = 1'b1; reg_wr_en = 1'b0; reg_wr_data = 8'h00;
    disp_addr = '0; row_scan = '0; host_addr = '0;
    repeat (3) @(posedge clk);
    #1 chk_en = 1'b1;
    // R1: reset value, outputs with page 0 and text mode
    cur_req = "R1";
    apply(1'b0, 'hFF, 'h123, 3, 'hB8010);
    apply(1'b0, 'h00, 'h1FFF, 1, 'hBC000);
    rst_n = 1'b1;
    apply(1'b0, 'h00, 'h0001, 2, 'hBFFFF);
    repeat (4) idle_mix(1);

    // R2: load on write, hold while strobe low
    cur_req = "R2";
    write_reg('h05);
    apply(1'b0, 'hFF, 'h0010, 0, 'hB8000);
    apply(1'b0, 'h3A, 'h0010, 0, 'hB8000);
    idle_mix(3);
    write_reg('h2B);
    apply(1'b0, 'hC7, 'h0100, 1, 'hBC123);
    idle_mix(3);

    // R3: every display page in text mode
    cur_req = "R3";
    for (int p = 0; p < 8; p++) begin
      write_reg(p);
      apply(1'b0, 0, 0, 0, 0);
      apply(1'b0, 0, 'h1FFF, 3, 'hB8000);
      idle_mix(2);
    end

    // R4: every host page, both halves of the window
    cur_req = "R4";
    for (int p = 0; p < 8; p++) begin
      write_reg(p * 8);
      apply(1'b0, 0, 0, 0, 'hB8000);
      apply(1'b0, 0, 0, 0, 'hBC000);
      apply(1'b0, 0, 0, 0, 'hBFFFF);
      apply(1'b0, 0, 0, 0, 'hB8000 + rnd(32768));
    end

    // R5: addresses just outside and far from the window
    cur_req = "R5";
    write_reg('h3F);
    apply(1'b0, 0, 0, 0, 'hB7FFF);
    apply(1'b0, 0, 0, 0, 'hC0000);
    apply(1'b0, 0, 0, 0, 'h00000);
    apply(1'b0, 0, 0, 0, 'hFFFFF);
    apply(1'b0, 0, 0, 0, 'h38000);
    apply(1'b0, 0, 0, 0, 'hA0000 + rnd(65536));

    // R6: no expansion memory masks top page bit
    cur_req = "R6";
    ext_ram_present = 1'b0;
    for (int p = 4; p < 8; p++) begin
      write_reg(p | (p * 8));
      apply(1'b0, 0, 'h0ABC, 1, 'hB9000);
      apply(1'b0, 0, 'h1234, 2, 'hBD000);
    end
    write_reg('hC5);
    idle_mix(3);
    ext_ram_present = 1'b1;
    idle_mix(2);

    // R7: text mode ignores row scan
    cur_req = "R7";
    write_reg('h03);
    for (int r = 0; r < 4; r++) apply(1'b0, 0, 'h1555, r, 'hB8000);
    idle_mix(4);

    // R8: low-resolution graphics
    cur_req = "R8";
    for (int p = 0; p < 8; p++) begin
      write_reg('h40 | p);
      for (int r = 0; r < 4; r++) apply(1'b0, 0, 'h1FFF - r, r, 'hB8000);
    end

    // R9: high-resolution graphics, odd pages aligned down
    cur_req = "R9";
    for (int p = 0; p < 8; p++) begin
      write_reg('hC0 | p);
      for (int r = 0; r < 4; r++) apply(1'b0, 0, 'h1ABC + r, r, 'hB8000);
    end

    // R10: reserved mode behaves as text
    cur_req = "R10";
    for (int p = 0; p < 8; p++) begin
      write_reg('h80 | p);
      apply(1'b0, 0, 'h1FFF, 3, 'hB8000);
      apply(1'b0, 0, 'h1001, 1, 'hB8000);
    end

    @(posedge clk);
    #1 chk_en = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule